// File: doc/BRIEF.md
# Gated Divide-by-N Pulse Rate Generator

This block is one timer channel. It divides a count strobe by a loaded value N and produces a periodic active-low pulse. The output stays high except for one count period in every N. Everything runs on one system clock. A single-cycle strobe, `cnt_en`, marks each count event. A new divisor written while the channel is running is held back until the current period ends, so the period in progress is never changed.

The `gate_in` input controls counting. While it is low, the counter freezes and the output is held high. When it rises, the count restarts from the initial value, which lets external logic line up the pulse phase. After reset, or after a `mode_set` strobe, the channel idles with its output high until a divisor is loaded.

Top module: `rategen_chan`

## Requirements
- R1: After a synchronous reset, `pulse_out` is 1, `count_now` reads 0, and the channel waits for a load.
- R2: While running with the gate high, `pulse_out` falls on the clock edge at which the count becomes 1. It rises again on the edge of the next count strobe, so it is low for exactly one count period.
- R3: Loading N in the waiting state makes `count_now` read N on the next clock. Each strobe with the gate high then decrements it. A strobe taken at count 1 reloads the initial value, so one period is N strobes.
- R4: A load while running does not change the current period. The new value becomes the initial value at the next reload.
- R5: While `gate_in` is 0, the count holds and `pulse_out` is 1 from the next clock.
- R6: A 0-to-1 transition of `gate_in` while running reloads the count with the latest loaded value, without decrementing, even if a strobe arrives in the same cycle.
- R7: In the waiting state, strobes and gate activity have no effect: `pulse_out` stays 1 and `count_now` stays 0.
- R8: A loaded value of 0 means 65536, and `count_now` then reads 0. A loaded value of 1 means 2.
- R9: `mode_set` discards any pending value and returns the channel to waiting, with `count_now` 0 and `pulse_out` 1. It takes priority over a load in the same cycle.
- R10: When `cnt_en` is 0 and no gate restart occurs, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | One-cycle count strobe |
| gate_in | input | 1 | Count gate; its rising edge restarts the count |
| load_valid | input | 1 | Divisor write strobe |
| load_value | input | CNT_W | Divisor value (0 means 2^CNT_W, 1 means 2) |
| mode_set | input | 1 | Returns the channel to the waiting state |
| pulse_out | output | 1 | Registered active-low rate pulse |
| count_now | output | CNT_W | Current counter value |

## Verification
The assertions assume that every input is synchronous to `clk` and is sampled once per edge. They also assume that `cnt_en`, `load_valid` and `mode_set` are plain level samples, with no meaning attached to how long they stay high. Gate edges are seen only by comparing `gate_in` with its value at the previous edge, so a glitch between edges is invisible by design. The stimulus changes every input only on the falling clock edge. It holds each input for whole cycles, and it places the same-cycle collisions (gate restart with a strobe, mode set with a load) on purpose.

// File: rtl/rategen_pkg.sv
package rategen_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } rg_state_e;
endpackage

// File: rtl/rategen_gate_edge.sv
module rategen_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate_in,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_in;
  end

  assign gate_rise = gate_in & ~gate_q;
endmodule

// File: rtl/rategen_reload.sv
module rategen_reload #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic             mode_set,
  input  logic             running,
  input  logic             take,
  output logic [CNT_W:0]   start_val,
  output logic [CNT_W:0]   next_init
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] init_q;
  logic [CW-1:0] pend_q;
  logic          pend_v;

  // R8: zero maps to full range, one is raised to two
  always_comb begin
    if (load_value == '0)
      start_val = {1'b1, {CNT_W{1'b0}}};
    else if (load_value == CNT_W'(1))
      start_val = CW'(2);
    else
      start_val = {1'b0, load_value};
  end

  assign next_init = pend_v ? pend_q : init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= CW'(2);
      pend_q <= CW'(2);
      pend_v <= 1'b0;
    end else if (mode_set) begin
      pend_v <= 1'b0;
    end else if (!running) begin
      if (load_valid) begin
        init_q <= start_val;
        pend_v <= 1'b0;
      end
    end else begin
      if (take) begin
        init_q <= next_init;
        pend_v <= 1'b0;
      end
      if (load_valid) begin
        pend_q <= start_val;
        pend_v <= 1'b1;
      end
    end
  end

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (take && running && !load_valid && !mode_set) |=> !pend_v);

  // R9
  mode_drop_pend_chk: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> !pend_v);

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (running && load_valid && !mode_set) |=> (pend_v && pend_q == $past(start_val)));
endmodule

// File: rtl/rategen_core.sv
module rategen_core
  import rategen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             gate_in,
  input  logic             gate_rise,
  input  logic             load_valid,
  input  logic             mode_set,
  input  logic [CNT_W:0]   start_val,
  input  logic [CNT_W:0]   next_init,
  output logic             take,
  output logic             running,
  output logic             out_q,
  output logic [CNT_W-1:0] count_low
);
  localparam int CW = CNT_W + 1;

  rg_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    take  = 1'b0;
    if (mode_set) begin
      st_d  = ST_WAIT;
      cnt_d = '0;
    end else if (st_q == ST_WAIT) begin
      if (load_valid) begin
        st_d  = ST_RUN;
        cnt_d = start_val;
      end
    end else if (gate_rise) begin
      cnt_d = next_init;
      take  = 1'b1;
    end else if (gate_in && cnt_en) begin
      if (cnt_q == CW'(1)) begin
        cnt_d = next_init;
        take  = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      out_q <= !((st_d == ST_RUN) && gate_in && (cnt_d == CW'(1)));
    end
  end

  assign running   = (st_q == ST_RUN);
  assign count_low = cnt_q[CNT_W-1:0];

  // R2
  pulse_one_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_q && cnt_en && gate_in && !mode_set) |=> out_q);

  // R5
  gate_low_high_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_in |=> out_q);

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !gate_in && !mode_set) |=> $stable(cnt_q));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !cnt_en && !gate_rise && !mode_set) |=> $stable(cnt_q));

  // R3
  run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt_q != '0));

  // R7
  wait_high_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> (out_q && cnt_q == '0));

  // R9
  mode_set_chk: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> (out_q && st_q == ST_WAIT && cnt_q == '0));
endmodule

// File: rtl/rategen_chan.sv
module rategen_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             gate_in,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic             mode_set,
  output logic             pulse_out,
  output logic [CNT_W-1:0] count_now
);
  logic           gate_rise;
  logic           take;
  logic           running;
  logic [CNT_W:0] start_val;
  logic [CNT_W:0] next_init;

  rategen_gate_edge u_gate (
    .clk       (clk),
    .rst       (rst),
    .gate_in   (gate_in),
    .gate_rise (gate_rise)
  );

  rategen_reload #(.CNT_W(CNT_W)) u_reload (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .load_value (load_value),
    .mode_set   (mode_set),
    .running    (running),
    .take       (take),
    .start_val  (start_val),
    .next_init  (next_init)
  );

  rategen_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .gate_in    (gate_in),
    .gate_rise  (gate_rise),
    .load_valid (load_valid),
    .mode_set   (mode_set),
    .start_val  (start_val),
    .next_init  (next_init),
    .take       (take),
    .running    (running),
    .out_q      (pulse_out),
    .count_low  (count_now)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (pulse_out && count_now == '0));
endmodule

// File: tb/rategen_chan_tb_top.sv
module rategen_chan_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        gate_in = 1'b0;
  logic        load_valid = 1'b0;
  logic [15:0] load_value = '0;
  logic        mode_set = 1'b0;
  logic        pulse_out;
  logic [15:0] count_now;

  rategen_chan #(.CNT_W(16)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .gate_in    (gate_in),
    .load_valid (load_valid),
    .load_value (load_value),
    .mode_set   (mode_set),
    .pulse_out  (pulse_out),
    .count_now  (count_now)
  );

  typedef struct {
    bit        out;
    bit [15:0] cnt;
    string     tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  // reference state, built from the requirements
  bit m_run = 0;
  int m_cnt = 0;
  int m_init = 2;
  int m_pend = 2;
  bit m_pv = 0;
  bit m_gprev = 0;
  bit m_out = 1;

  task automatic step(bit r, bit t, bit g, bit ld, int v, bit ms, string tag);
    int  norm;
    int  nxt;
    bit  rise;
    bit  tk;
    exp_t it;
    @(negedge clk);
    rst = r; cnt_en = t; gate_in = g; load_valid = ld;
    load_value = 16'(v); mode_set = ms;
    norm = (v == 0) ? 65536 : ((v == 1) ? 2 : v);
    rise = g && !m_gprev;
    if (r) begin
      m_run = 0; m_cnt = 0; m_pv = 0; m_init = 2;
    end else if (ms) begin
      m_run = 0; m_cnt = 0; m_pv = 0;
    end else if (!m_run) begin
      if (ld) begin
        m_run = 1; m_cnt = norm; m_init = norm; m_pv = 0;
      end
    end else begin
      nxt = m_pv ? m_pend : m_init;
      tk = 0;
      if (rise) begin
        m_cnt = nxt; tk = 1;
      end else if (g && t) begin
        if (m_cnt == 1) begin m_cnt = nxt; tk = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (tk) begin m_init = nxt; m_pv = 0; end
      if (ld) begin m_pend = norm; m_pv = 1; end
    end
    m_gprev = r ? 1'b0 : g;
    m_out = !(m_run && g && m_cnt == 1);
    it.out = m_out;
    it.cnt = 16'(m_cnt);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 1, 1, 0, 0, 0, tag);
  endtask

  // monitor: compare after each edge, away from the next falling edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (pulse_out !== e.out || count_now !== e.cnt) begin
        n_err++;
        $display("FAIL %s: actual out=%0b count=%0d expected out=%0b count=%0d",
                 e.tag, pulse_out, count_now, e.out, e.cnt);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step(1, 1, 1, 0, 0, 0, "R1");
    // R7 waiting: strobes and gate ignored
    step(0, 1, 1, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 0, "R7");
    // R3 load 4, gate high
    step(0, 0, 1, 1, 4, 0, "R3");
    ticks(12, "R2");
    // R10 no strobe holds count
    step(0, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 1, 0, 0, 0, "R10");
    step(0, 1, 1, 0, 0, 0, "R10");
    step(0, 0, 1, 0, 0, 0, "R10");
    // R4 mid-period write takes effect at next reload
    step(0, 1, 1, 1, 6, 0, "R4");
    ticks(16, "R4");
    // R5 gate low freezes and forces high
    repeat (4) step(0, 1, 0, 0, 0, 0, "R5");
    // R6 gate rise with strobe restarts
    ticks(8, "R6");
    step(0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 1, 9, 0, "R6");
    step(0, 1, 0, 0, 0, 0, "R6");
    ticks(10, "R6");
    // R8 value 1 behaves as 2
    step(0, 1, 1, 1, 1, 0, "R8");
    ticks(14, "R8");
    // R9 mode set then R8 value 0 as 65536
    step(0, 0, 1, 0, 0, 1, "R9");
    step(0, 1, 1, 0, 0, 0, "R9");
    step(0, 0, 1, 1, 0, 0, "R8");
    ticks(3, "R8");
    // R9 mode set beats load in same cycle
    step(0, 1, 1, 1, 5, 1, "R9");
    ticks(3, "R9");
    // R9 pending value dropped by mode set
    step(0, 0, 1, 1, 5, 0, "R9");
    ticks(2, "R9");
    step(0, 1, 1, 1, 3, 0, "R9");
    step(0, 0, 1, 0, 0, 1, "R9");
    step(0, 0, 1, 1, 7, 0, "R9");
    ticks(16, "R9");
    step(0, 0, 1, 0, 0, 0, "R9");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule